// File: doc/BRIEF.md
# Serial Identity Selection Layer

This block sits directly above a single-wire bit engine. Whenever the bit engine reports a bus reset, the block waits for one 8-bit function code. The code arrives as eight write slots, least significant bit first. The code then picks one of three identity operations against a 64-bit identity word that the block receives on an input port. Bits 7:0 of that word hold the family code (09h by default), bits 55:8 hold a 48-bit serial number, and bits 63:56 hold a CRC-8 (polynomial x^8 + x^5 + x^4 + 1) computed over bits 55:0.

Code 33h streams the whole identity word out over 64 read slots. Code 55h compares 64 incoming write bits against the identity word. Code CCh selects the device at once, with no identity transfer. A successful operation sets a selected flag, which enables the memory command layer above this block. In the same cycle a one-cycle hand-off strobe fires, and from that point the memory layer interprets every later slot. Any other code, or a single mismatching bit during a compare, makes the block inert until the next bus reset.

Top module: `id_select`

## Requirements
- R1: While `rst_ni` is low, and in the cycle after any `bus_reset_i` pulse, `selected_o` and `handoff_o` are 0, `rd_bit_o` is 1, and the block waits for a new function code.
- R2: The function code is taken from the next 8 write slots after a bus reset. The first slot is bit 0 of the code.
- R3: After code 33h, read slot k (k = 0..63) returns bit k of `id_word_i`. The host therefore receives the family code byte first and the CRC byte last, each byte least significant bit first.
- R4: After code 33h, `selected_o` rises in the cycle after the 64th read slot, and not earlier.
- R5: After code 55h, if all 64 written bits equal bits 0..63 of `id_word_i` in order, `selected_o` rises in the cycle after the 64th write slot, and not earlier.
- R6: During a 55h compare, the first bit that differs from the identity word ends the operation. Every later slot is ignored until a bus reset: `selected_o` stays 0 and `rd_bit_o` stays 1.
- R7: Code CCh sets `selected_o` in the cycle after the 8th code bit.
- R8: Any code other than 33h, 55h or CCh (for example F0h, AAh or 0Fh) leaves the block unselected until a bus reset. Later read slots return 1, and later write slots cannot select it.
- R9: `handoff_o` is high for exactly one cycle, namely the first cycle in which `selected_o` is 1.
- R10: Once set, `selected_o` stays at 1 through any slots until a bus reset clears it. A bus reset at any point, including partway through a read-out, returns the block to code collection.
- R11: `rd_bit_o` is 1 except during a 33h read-out. Write slots issued during a read-out neither change the bit order nor advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_reset_i | input | 1 | One-cycle strobe from the bit engine: reset pulse seen on the line |
| wr_valid_i | input | 1 | One-cycle strobe: the host wrote a bit |
| wr_bit_i | input | 1 | Value of the written bit |
| rd_req_i | input | 1 | One-cycle strobe: the host opened a read slot |
| rd_bit_o | output | 1 | Bit to return in the current read slot (1 releases the line) |
| id_word_i | input | 64 | Identity word: family code in [7:0], serial number in [55:8], CRC in [63:56] |
| selected_o | output | 1 | Device is selected; enables the memory command layer |
| handoff_o | output | 1 | One-cycle strobe when selection completes |

## Verification
A wrong slot counter shows up on `rd_bit_o` in the very read slot where it goes astray. It also shifts the cycle in which `selected_o` rises by the same number of slots, so the bench samples both at every slot boundary. A wrong state after a code or after a mismatch becomes visible within one cycle: either as a premature `selected_o`, or as a read slot that returns identity data when it should return 1. A stale selection that survives a bus reset is visible in the cycle after the pulse.

// File: rtl/id_select_pkg.sv
package id_select_pkg;
  typedef enum logic [2:0] {
    ST_CODE,
    ST_SEND,
    ST_MATCH,
    ST_SEL,
    ST_DEAD
  } sel_state_e;

  localparam logic [7:0] CODE_READ_ID  = 8'h33;
  localparam logic [7:0] CODE_MATCH_ID = 8'h55;
  localparam logic [7:0] CODE_SKIP_ID  = 8'hCC;
endpackage

// File: rtl/id_select_shift.sv
module id_select_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] q;

  // lsb-first: the newest bit enters at the top
  assign nxt_o = {bit_i, q[W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (en_i) q <= nxt_o;
  end
endmodule

// File: rtl/id_select_cnt.sv
module id_select_cnt #(
  parameter int N = 64,
  localparam int CW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_o <= '0;
    else if (clr_i)  idx_o <= '0;
    else if (inc_i)  idx_o <= idx_o + 1'b1;
  end
endmodule

// File: rtl/id_select.sv
module id_select
  import id_select_pkg::*;
#(
  parameter int ID_W = 64,
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] CODE_READ  = CODE_READ_ID,
  parameter logic [CODE_W-1:0] CODE_MATCH = CODE_MATCH_ID,
  parameter logic [CODE_W-1:0] CODE_SKIP  = CODE_SKIP_ID
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_reset_i,
  input  logic            wr_valid_i,
  input  logic            wr_bit_i,
  input  logic            rd_req_i,
  output logic            rd_bit_o,
  input  logic [ID_W-1:0] id_word_i,
  output logic            selected_o,
  output logic            handoff_o
);
  localparam int CNT_W = $clog2(ID_W);
  localparam logic [CNT_W-1:0] CODE_LAST = CNT_W'(CODE_W - 1);
  localparam logic [CNT_W-1:0] ID_LAST   = CNT_W'(ID_W - 1);

  sel_state_e        st_q, st_d;
  logic [CNT_W-1:0]  idx;
  logic              cnt_clr, cnt_inc, shift_en;
  logic [CODE_W-1:0] code_nxt;
  logic              handoff_q;

  id_select_shift #(.W(CODE_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (shift_en),
    .bit_i  (wr_bit_i),
    .nxt_o  (code_nxt)
  );

  id_select_cnt #(.N(ID_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .idx_o  (idx)
  );

  always_comb begin
    st_d     = st_q;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    shift_en = 1'b0;
    if (bus_reset_i) begin
      st_d    = ST_CODE;
      cnt_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_CODE: if (wr_valid_i) begin
          shift_en = 1'b1;
          if (idx == CODE_LAST) begin
            cnt_clr = 1'b1;
            if (code_nxt == CODE_READ)       st_d = ST_SEND;
            else if (code_nxt == CODE_MATCH) st_d = ST_MATCH;
            else if (code_nxt == CODE_SKIP)  st_d = ST_SEL;
            else                             st_d = ST_DEAD;
          end else begin
            cnt_inc = 1'b1;
          end
        end
        ST_SEND: if (rd_req_i) begin
          if (idx == ID_LAST) begin
            cnt_clr = 1'b1;
            st_d    = ST_SEL;
          end else begin
            cnt_inc = 1'b1;
          end
        end
        ST_MATCH: if (wr_valid_i) begin
          if (wr_bit_i != id_word_i[idx]) begin
            cnt_clr = 1'b1;
            st_d    = ST_DEAD;
          end else if (idx == ID_LAST) begin
            cnt_clr = 1'b1;
            st_d    = ST_SEL;
          end else begin
            cnt_inc = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_CODE;
      handoff_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      handoff_q <= (st_d == ST_SEL) && (st_q != ST_SEL);
    end
  end

  assign rd_bit_o   = (st_q == ST_SEND) ? id_word_i[idx] : 1'b1;
  assign selected_o = (st_q == ST_SEL);
  assign handoff_o  = handoff_q;
endmodule

// File: rtl/id_select_chk.sv
module id_select_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_reset_i,
  input logic wr_valid_i,
  input logic rd_req_i,
  input logic rd_bit_o,
  input logic selected_o,
  input logic handoff_o
);
  AST_RESET_DESELECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> !selected_o && !handoff_o); // R10

  AST_SEL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    selected_o && !bus_reset_i |=> selected_o); // R10

  AST_HANDOFF_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(selected_o) |-> handoff_o); // R9

  AST_HANDOFF_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handoff_o |=> !handoff_o); // R9

  AST_HANDOFF_WITH_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handoff_o |-> selected_o); // R9

  AST_SEL_AFTER_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(selected_o) |-> $past(wr_valid_i || rd_req_i) && !$past(bus_reset_i)); // R4

  AST_SEL_RELEASES_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    selected_o |-> rd_bit_o); // R11
endmodule

bind id_select id_select_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_reset_i (bus_reset_i),
  .wr_valid_i  (wr_valid_i),
  .rd_req_i    (rd_req_i),
  .rd_bit_o    (rd_bit_o),
  .selected_o  (selected_o),
  .handoff_o   (handoff_o)
);

// File: tb/id_select_bench.sv
module id_select_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_reset_i = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic        wr_bit_i = 1'b0;
  logic        rd_req_i = 1'b0;
  logic        rd_bit_o;
  logic [63:0] id_word_i;
  logic        selected_o;
  logic        handoff_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  id_select u_id_select (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_reset_i(bus_reset_i),
    .wr_valid_i(wr_valid_i), .wr_bit_i(wr_bit_i), .rd_req_i(rd_req_i),
    .rd_bit_o(rd_bit_o), .id_word_i(id_word_i),
    .selected_o(selected_o), .handoff_o(handoff_o)
  );

  // reference CRC-8, x^8+x^5+x^4+1, bits taken lsb first
  function automatic logic [7:0] crc8_step(logic [7:0] c, logic b);
    logic fb;
    fb = c[0] ^ b;
    c  = c >> 1;
    if (fb) c = c ^ 8'h8C;
    return c;
  endfunction

  function automatic logic [7:0] crc8_of(logic [63:0] w, int nbits);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < nbits; i++) c = crc8_step(c, w[i]);
    return c;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_bus_reset();
    @(negedge clk_i) bus_reset_i = 1'b1;
    @(negedge clk_i) bus_reset_i = 1'b0;
  endtask

  task automatic wr_slot(logic b);
    @(negedge clk_i) begin wr_valid_i = 1'b1; wr_bit_i = b; end
    @(negedge clk_i) wr_valid_i = 1'b0;
  endtask

  task automatic send_code(logic [7:0] c);
    for (int i = 0; i < 8; i++) wr_slot(c[i]);
  endtask

  task automatic rd_slot(output logic b);
    @(negedge clk_i) begin b = rd_bit_o; rd_req_i = 1'b1; end
    @(negedge clk_i) rd_req_i = 1'b0;
  endtask

  // {code, selected after code, first read bit returns id bit 0}
  localparam logic [9:0] VEC [6] = '{
    {8'hCC, 1'b1, 1'b0},
    {8'h33, 1'b0, 1'b1},
    {8'h55, 1'b0, 1'b0},
    {8'hF0, 1'b0, 1'b0},
    {8'hAA, 1'b0, 1'b0},
    {8'h0F, 1'b0, 1'b0}
  };

  localparam logic [55:0] ID_LOW = {48'h1A2B3C4D5E6F, 8'h09};

  initial begin
    logic b;
    logic [63:0] got;
    id_word_i = {crc8_of({8'h00, ID_LOW}, 56), ID_LOW};

    repeat (3) @(negedge clk_i);
    check("R1 reset selected", selected_o, 0);
    check("R1 reset rd_bit", rd_bit_o, 1);
    check("R1 reset handoff", handoff_o, 0);
    rst_ni = 1'b1;

    for (int v = 0; v < 6; v++) begin
      pulse_bus_reset();
      send_code(VEC[v][9:2]);
      check($sformatf("R2 R7 R8 code %0h selected", VEC[v][9:2]), selected_o, VEC[v][1]);
      check($sformatf("R11 code %0h rd_bit", VEC[v][9:2]), rd_bit_o,
            VEC[v][0] ? id_word_i[0] : 1'b1);
    end

    // R3 R4 R11: read-out, with a stray write slot first
    pulse_bus_reset();
    send_code(8'h33);
    wr_slot(1'b0);
    got = '0;
    for (int i = 0; i < 64; i++) begin
      if (i == 63) check("R4 not selected early", selected_o, 0);
      rd_slot(b);
      got[i] = b;
    end
    check("R3 R11 streamed word", got, id_word_i);
    check("R3 stored crc matches model", got[63:56], crc8_of(got, 56));
    check("R3 crc over full word", crc8_of(got, 64), 0);
    check("R4 selected after 64th read", selected_o, 1);
    check("R9 handoff first cycle", handoff_o, 1);
    @(negedge clk_i);
    check("R9 handoff one cycle", handoff_o, 0);
    rd_slot(b);
    for (int i = 0; i < 16; i++) wr_slot(i[0]);
    check("R10 read after selection", b, 1);
    check("R10 still selected", selected_o, 1);
    check("R9 no second handoff", handoff_o, 0);

    // R5: full match
    pulse_bus_reset();
    check("R10 reset clears selection", selected_o, 0);
    send_code(8'h55);
    for (int i = 0; i < 64; i++) begin
      if (i == 63) check("R5 not selected early", selected_o, 0);
      wr_slot(id_word_i[i]);
    end
    check("R5 selected after match", selected_o, 1);
    check("R9 handoff after match", handoff_o, 1);

    // R6: mismatch at bit 5, rest correct, then a full correct word
    pulse_bus_reset();
    send_code(8'h55);
    for (int i = 0; i < 64; i++) wr_slot(i == 5 ? ~id_word_i[i] : id_word_i[i]);
    for (int i = 0; i < 64; i++) wr_slot(id_word_i[i]);
    check("R6 dropped after mismatch", selected_o, 0);
    rd_slot(b);
    check("R6 read after mismatch", b, 1);

    // R8: unknown code, then reads and a skip code have no effect
    pulse_bus_reset();
    send_code(8'hF0);
    got = '0;
    for (int i = 0; i < 64; i++) begin rd_slot(b); got[i] = b; end
    check("R8 reads all ones", got, 64'hFFFF_FFFF_FFFF_FFFF);
    send_code(8'hCC);
    check("R8 skip ignored when inert", selected_o, 0);

    // R2: msb-first CCh is lsb-first 33h, so a read-out starts
    pulse_bus_reset();
    for (int i = 7; i >= 0; i--) wr_slot(8'hCC >> i);
    check("R2 bit order not selected", selected_o, 0);
    rd_slot(b);
    rd_slot(b);
    check("R2 bit order read-out bit1", b, id_word_i[1]);

    // R10: bus reset mid read-out
    pulse_bus_reset();
    send_code(8'h33);
    for (int i = 0; i < 10; i++) rd_slot(b);
    pulse_bus_reset();
    check("R10 rd_bit after mid reset", rd_bit_o, 1);
    send_code(8'hCC);
    check("R7 R10 skip after mid reset", selected_o, 1);

    // R1: async reset while selected
    @(negedge clk_i) rst_ni = 1'b0;
    #1;
    check("R1 async reset", selected_o, 0);
    @(negedge clk_i) rst_ni = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule